// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit resolves one instruction operand. Given a three-bit mode code, a register index, a constant taken from the instruction and a flag saying whether the operand is a destination, it reads the base register through a register-file read port, forms the effective address, and fetches the operand through a synchronous memory read port. Depending on the mode it makes zero, one or two memory reads. The result appears together with a one-cycle done strobe. For the two pointer-stepping modes it also returns the stepped base register on a write port in that same cycle.

Addresses count bytes, and a word is `WORD_W/8` bytes wide, so the step is 4 with the default 32-bit word. Setting `BYTE_ADDR` to 0 turns the step into 1 for a word-addressed system. The unit accepts a request only while idle. `busy` tells the issuing stage when the next request may be sent.

Top module: `opnd_locate`

## Requirements
- R1: Mode code 3'd0 (register): the operand is the base register's contents, no memory read is made, and there is no register write.
- R2: Mode code 3'd1 (immediate) on a source request: the operand is the instruction constant sign-extended to `WORD_W`. No memory read is made.
- R3: Mode code 3'd2 (absolute): the constant, zero-extended, is the address of a single memory read. The operand is the word returned.
- R4: Mode code 3'd3 (register-indirect): the base register's contents are the address of a single memory read.
- R5: Mode code 3'd4 (memory-indirect): the first read uses the zero-extended constant as its address. The second read uses the word returned by the first. The operand is the word from the second read, and `opnd_addr` equals the second read address.
- R6: Mode code 3'd5 (indexed): the read address is the sign-extended constant plus the base register.
- R7: Mode code 3'd6 (autoincrement): the read address is the base register. The base register plus one word step is written back to the same register index.
- R8: Mode code 3'd7 (autodecrement): the base register minus one word step is both the read address and the value written back.
- R9: `done` is high for exactly one cycle per accepted request. A register write-back (`rf_wr_en`) occurs only in that cycle.
- R10: Mode code 3'd1 on a destination request (`req_is_dst`=1) raises `illegal` in the done cycle. It makes no memory read and no register write.
- R11: A request is accepted only while `busy` is low. `busy` stays high from the cycle after acceptance through the done cycle. A request presented while busy is ignored.
- R12: `done` is high in the 1st cycle after the accepting edge for modes with no read, the 3rd cycle for one read, and the 5th cycle for two reads.
- R13: During reset, `busy`, `done`, `mem_rd_en` and `rf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_is_dst | input | 1 | Operand is a destination |
| req_mode | input | 3 | Mode code |
| req_reg_idx | input | RIDX_W | Base register index |
| req_const | input | CONST_W | Instruction constant |
| rf_rd_idx | output | RIDX_W | Register read index (follows req_reg_idx) |
| rf_rd_data | input | WORD_W | Register read data, combinational |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | WORD_W | Memory read byte address |
| mem_rd_data | input | WORD_W | Read data, valid the cycle after the strobe |
| rf_wr_en | output | 1 | Base register write-back |
| rf_wr_idx | output | RIDX_W | Write-back register index |
| rf_wr_data | output | WORD_W | Stepped base value |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid, one cycle |
| illegal | output | 1 | Immediate used as destination |
| opnd_value | output | WORD_W | Operand value |
| opnd_addr | output | WORD_W | Final effective address |

## Verification
The hardest case to reach is a request arriving while the unit is still busy. A stall-free issuing stage never offers one, so the stimulus holds `req_valid` high with a different register-mode request during the wait cycles of an absolute read. It then confirms that only the first operand completes and that no second done follows. The memory-indirect chain is reached by loading a pointer word into the bench memory, so that the second read address can only be right if the first read's data was carried into it. The stepping modes are confirmed by reading the same register again in register mode after the write-back.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

   typedef enum logic [2:0] {
      OPM_REG  = 3'd0,
      OPM_IMM  = 3'd1,
      OPM_ABS  = 3'd2,
      OPM_RIND = 3'd3,
      OPM_MIND = 3'd4,
      OPM_IDX  = 3'd5,
      OPM_AINC = 3'd6,
      OPM_ADEC = 3'd7
   } opm_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_RD1,
      SQ_WT1,
      SQ_RD2,
      SQ_WT2,
      SQ_FIN
   } sq_e;

   // number of memory reads a mode needs
   function automatic logic [1:0] reads_for(opm_e m);
      case (m)
         OPM_REG, OPM_IMM: reads_for = 2'd0;
         OPM_MIND:         reads_for = 2'd2;
         default:          reads_for = 2'd1;
      endcase
   endfunction

   function automatic logic steps_base(opm_e m);
      steps_base = (m == OPM_AINC) || (m == OPM_ADEC);
   endfunction

endpackage

// File: rtl/opnd_ea_calc.sv
module opnd_ea_calc
   import opnd_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int CONST_W   = 16,
   parameter bit BYTE_ADDR = 1'b1
) (
   input  opm_e              mode,
   input  logic [WORD_W-1:0] base,
   input  logic [CONST_W-1:0] cnst,
   output logic [WORD_W-1:0] ea,
   output logic [WORD_W-1:0] nbase,
   output logic [WORD_W-1:0] imm_val
);

   localparam int STEP = BYTE_ADDR ? (WORD_W / 8) : 1;

   logic [WORD_W-1:0] step;
   logic [WORD_W-1:0] sx;
   logic [WORD_W-1:0] zx;

   generate
      if (CONST_W > WORD_W) begin : g_bad_const
         $error("opnd_ea_calc: CONST_W must not exceed WORD_W");
      end
      if (BYTE_ADDR && (WORD_W % 8 != 0)) begin : g_bad_word
         $error("opnd_ea_calc: WORD_W must be whole bytes when BYTE_ADDR is set");
      end
      if (BYTE_ADDR) begin : g_byte_step
         assign step = WORD_W'(STEP);
      end else begin : g_word_step
         assign step = WORD_W'(1);
      end
   endgenerate

   assign sx      = WORD_W'($signed(cnst));
   assign zx      = WORD_W'(cnst);
   assign imm_val = sx;

   always_comb begin
      nbase = base;
      case (mode)
         OPM_ABS:  ea = zx;
         OPM_RIND: ea = base;
         OPM_MIND: ea = zx;
         OPM_IDX:  ea = sx + base;
         OPM_AINC: begin
            ea    = base;
            nbase = base + step;
         end
         OPM_ADEC: begin
            ea    = base - step;
            nbase = base - step;
         end
         default:  ea = '0;
      endcase
   end

endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
   import opnd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] nrd,
   output sq_e        state
);

   sq_e  nxt;
   logic two_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         two_q <= 1'b0;
      end else begin
         state <= nxt;
         if (start && state == SQ_IDLE) two_q <= (nrd == 2'd2);
      end
   end

   always_comb begin
      nxt = state;
      case (state)
         SQ_IDLE: if (start) nxt = (nrd == 2'd0) ? SQ_FIN : SQ_RD1;
         SQ_RD1:  nxt = SQ_WT1;
         SQ_WT1:  nxt = two_q ? SQ_RD2 : SQ_FIN;
         SQ_RD2:  nxt = SQ_WT2;
         SQ_WT2:  nxt = SQ_FIN;
         SQ_FIN:  nxt = SQ_IDLE;
         default: nxt = SQ_IDLE;
      endcase
   end

endmodule

// File: rtl/opnd_locate.sv
module opnd_locate
   import opnd_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int CONST_W   = 16,
   parameter int REG_N     = 16,
   parameter bit BYTE_ADDR = 1'b1,
   localparam int RIDX_W   = (REG_N > 1) ? $clog2(REG_N) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_is_dst,
   input  logic [2:0]         req_mode,
   input  logic [RIDX_W-1:0]  req_reg_idx,
   input  logic [CONST_W-1:0] req_const,
   output logic [RIDX_W-1:0]  rf_rd_idx,
   input  logic [WORD_W-1:0]  rf_rd_data,
   output logic               mem_rd_en,
   output logic [WORD_W-1:0]  mem_rd_addr,
   input  logic [WORD_W-1:0]  mem_rd_data,
   output logic               rf_wr_en,
   output logic [RIDX_W-1:0]  rf_wr_idx,
   output logic [WORD_W-1:0]  rf_wr_data,
   output logic               busy,
   output logic               done,
   output logic               illegal,
   output logic [WORD_W-1:0]  opnd_value,
   output logic [WORD_W-1:0]  opnd_addr
);

   generate
      if (REG_N < 2) begin : g_bad_regs
         $error("opnd_locate: REG_N must be at least 2");
      end
   endgenerate

   sq_e               state;
   opm_e              req_m;
   opm_e              mode_q;
   logic              accept;
   logic              bad_req;
   logic [1:0]        nrd;
   logic              bad_q;
   logic [CONST_W-1:0] cnst_q;
   logic [WORD_W-1:0] base_q;
   logic [RIDX_W-1:0] ridx_q;
   logic [WORD_W-1:0] ptr_q;
   logic [WORD_W-1:0] val_q;
   logic [WORD_W-1:0] ea;
   logic [WORD_W-1:0] nbase;
   logic [WORD_W-1:0] imm_val;

   assign req_m     = opm_e'(req_mode);
   assign accept    = req_valid && (state == SQ_IDLE);
   assign bad_req   = req_is_dst && (req_m == OPM_IMM);
   assign nrd       = bad_req ? 2'd0 : reads_for(req_m);
   assign rf_rd_idx = req_reg_idx;

   opnd_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .nrd   (nrd),
      .state (state)
   );

   opnd_ea_calc #(
      .WORD_W    (WORD_W),
      .CONST_W   (CONST_W),
      .BYTE_ADDR (BYTE_ADDR)
   ) u_ea (
      .mode    (mode_q),
      .base    (base_q),
      .cnst    (cnst_q),
      .ea      (ea),
      .nbase   (nbase),
      .imm_val (imm_val)
   );

   // request capture
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= OPM_REG;
         bad_q  <= 1'b0;
         cnst_q <= '0;
         base_q <= '0;
         ridx_q <= '0;
      end else if (accept) begin
         mode_q <= req_m;
         bad_q  <= bad_req;
         cnst_q <= req_const;
         base_q <= rf_rd_data;
         ridx_q <= req_reg_idx;
      end
   end

   // read data capture
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         val_q <= '0;
      end else begin
         if (state == SQ_WT1) begin
            if (mode_q == OPM_MIND) ptr_q <= mem_rd_data;
            else                    val_q <= mem_rd_data;
         end
         if (state == SQ_WT2) val_q <= mem_rd_data;
      end
   end

   assign busy        = (state != SQ_IDLE);
   assign done        = (state == SQ_FIN);
   assign mem_rd_en   = (state == SQ_RD1) || (state == SQ_RD2);
   assign mem_rd_addr = (state == SQ_RD2) ? ptr_q : ea;
   assign illegal     = done && bad_q;
   assign rf_wr_en    = done && !bad_q && steps_base(mode_q);
   assign rf_wr_idx   = ridx_q;
   assign rf_wr_data  = nbase;
   assign opnd_addr   = (mode_q == OPM_MIND) ? ptr_q : ea;

   always_comb begin
      case (mode_q)
         OPM_REG: opnd_value = base_q;
         OPM_IMM: opnd_value = bad_q ? '0 : imm_val;
         default: opnd_value = val_q;
      endcase
   end

endmodule

// File: rtl/opnd_locate_chk.sv
module opnd_locate_chk
   import opnd_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic mem_rd_en,
   input logic rf_wr_en,
   input logic illegal,
   input opm_e mode_q
);

   a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_wb_only_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |-> done);

   a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   a_r11_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!rf_wr_en && !mem_rd_en));

   a_r1_reg_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_q == OPM_REG) |-> !mem_rd_en);

   a_r2_imm_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_q == OPM_IMM) |-> !mem_rd_en);

   a_r11_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_rd_en);

endmodule

bind opnd_locate opnd_locate_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .mem_rd_en (mem_rd_en),
   .rf_wr_en  (rf_wr_en),
   .illegal   (illegal),
   .mode_q    (mode_q)
);

// File: tb/opnd_locate_test.sv
`timescale 1ns/1ps
module opnd_locate_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_is_dst = 1'b0;
   logic [2:0]  req_mode = 3'd0;
   logic [3:0]  req_reg_idx = 4'd0;
   logic [15:0] req_const = 16'd0;
   logic [3:0]  rf_rd_idx;
   logic [31:0] rf_rd_data;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [31:0] mem_rd_data = 32'd0;
   logic        rf_wr_en;
   logic [3:0]  rf_wr_idx;
   logic [31:0] rf_wr_data;
   logic        busy, done, illegal;
   logic [31:0] opnd_value, opnd_addr;

   logic [31:0] rf  [16];
   logic [31:0] mem [256];

   int n_chk  = 0;
   int n_fail = 0;

   // results of the last operation
   logic [31:0] r_val, r_addr, r_a1, r_a2, r_wbdat;
   logic [3:0]  r_wbidx;
   logic        r_wb, r_ill, r_pulse_ok, r_busy_ok;
   int          r_lat, r_nrd;

   always #2.5 clk = ~clk;

   opnd_locate uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_dst(req_is_dst),
      .req_mode(req_mode), .req_reg_idx(req_reg_idx), .req_const(req_const),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
      .busy(busy), .done(done), .illegal(illegal),
      .opnd_value(opnd_value), .opnd_addr(opnd_addr)
   );

   assign rf_rd_data = rf[rf_rd_idx];

   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:2]];
      if (rf_wr_en)  rf[rf_wr_idx] <= rf_wr_data;
   end

   function automatic logic [31:0] memv(input logic [31:0] a);
      return mem[a[9:2]];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic dst, input logic [2:0] m, input logic [3:0] ri,
                         input logic [15:0] c);
      logic got;
      @(negedge clk);
      req_valid = 1'b1; req_is_dst = dst; req_mode = m; req_reg_idx = ri; req_const = c;
      @(negedge clk);
      req_valid = 1'b0;
      got = 1'b0; r_nrd = 0; r_lat = 0; r_busy_ok = 1'b1; r_wb = 1'b0; r_ill = 1'b0;
      r_a1 = '0; r_a2 = '0;
      for (int k = 1; k <= 12 && !got; k++) begin
         if (k > 1) @(negedge clk);
         if (!busy) r_busy_ok = 1'b0;
         if (mem_rd_en) begin
            if (r_nrd == 0) r_a1 = mem_rd_addr; else r_a2 = mem_rd_addr;
            r_nrd++;
         end
         if (done) begin
            got = 1'b1; r_lat = k; r_val = opnd_value; r_addr = opnd_addr;
            r_wb = rf_wr_en; r_wbidx = rf_wr_idx; r_wbdat = rf_wr_data; r_ill = illegal;
         end
      end
      @(negedge clk);
      r_pulse_ok = !done && !busy;
   endtask

   task automatic t_reset;
      chk("R13 busy in reset", {31'd0, busy}, 32'd0);
      chk("R13 done in reset", {31'd0, done}, 32'd0);
      chk("R13 mem_rd_en in reset", {31'd0, mem_rd_en}, 32'd0);
      chk("R13 rf_wr_en in reset", {31'd0, rf_wr_en}, 32'd0);
   endtask

   task automatic t_reg;
      run_op(1'b0, 3'd0, 4'd5, 16'h1234);
      chk("R1 register value", r_val, 32'h150);
      chk("R1 no read", r_nrd, 0);
      chk("R1 no write-back", {31'd0, r_wb}, 32'd0);
      chk("R12 latency no read", r_lat, 1);
      chk("R9 done pulse", {31'd0, r_pulse_ok}, 32'd1);
   endtask

   task automatic t_imm;
      run_op(1'b0, 3'd1, 4'd2, 16'hFFF0);
      chk("R2 immediate sign-extended", r_val, 32'hFFFF_FFF0);
      chk("R2 no read", r_nrd, 0);
      chk("R2 not illegal on source", {31'd0, r_ill}, 32'd0);
      run_op(1'b0, 3'd1, 4'd2, 16'h0123);
      chk("R2 immediate positive", r_val, 32'h0000_0123);
   endtask

   task automatic t_abs;
      run_op(1'b0, 3'd2, 4'd1, 16'h0088);
      chk("R3 absolute address", r_a1, 32'h88);
      chk("R3 absolute value", r_val, memv(32'h88));
      chk("R3 one read", r_nrd, 1);
      chk("R12 latency one read", r_lat, 3);
      chk("R11 busy through op", {31'd0, r_busy_ok}, 32'd1);
      run_op(1'b0, 3'd2, 4'd1, 16'h8004);
      chk("R3 constant zero-extended", r_a1, 32'h0000_8004);
      chk("R3 value high constant", r_val, memv(32'h8004));
   endtask

   task automatic t_rind;
      run_op(1'b0, 3'd3, 4'd3, 16'hFFFF);
      chk("R4 indirect address", r_a1, 32'h130);
      chk("R4 indirect value", r_val, memv(32'h130));
      chk("R4 one read", r_nrd, 1);
   endtask

   task automatic t_mind;
      run_op(1'b0, 3'd4, 4'd0, 16'h0040);
      chk("R5 reads", r_nrd, 2);
      chk("R5 first address", r_a1, 32'h40);
      chk("R5 second address", r_a2, 32'h200);
      chk("R5 value", r_val, memv(32'h200));
      chk("R5 opnd_addr", r_addr, 32'h200);
      chk("R12 latency two reads", r_lat, 5);
      chk("R9 done pulse two reads", {31'd0, r_pulse_ok}, 32'd1);
   endtask

   task automatic t_idx;
      run_op(1'b0, 3'd5, 4'd4, 16'hFFF8);
      chk("R6 indexed negative offset", r_a1, 32'h138);
      chk("R6 indexed value", r_val, memv(32'h138));
      run_op(1'b0, 3'd5, 4'd4, 16'h0010);
      chk("R6 indexed positive offset", r_a1, 32'h150);
   endtask

   task automatic t_ainc;
      run_op(1'b0, 3'd6, 4'd6, 16'h0000);
      chk("R7 read address", r_a1, 32'h160);
      chk("R7 value", r_val, memv(32'h160));
      chk("R7 write-back in done", {31'd0, r_wb}, 32'd1);
      chk("R7 write-back index", {28'd0, r_wbidx}, 32'd6);
      chk("R7 write-back value", r_wbdat, 32'h164);
      run_op(1'b0, 3'd0, 4'd6, 16'h0000);
      chk("R7 register updated", r_val, 32'h164);
   endtask

   task automatic t_adec;
      run_op(1'b0, 3'd7, 4'd7, 16'h0000);
      chk("R8 read address", r_a1, 32'h16C);
      chk("R8 value", r_val, memv(32'h16C));
      chk("R8 write-back value", r_wbdat, 32'h16C);
      chk("R9 write-back with done", {31'd0, r_wb}, 32'd1);
      run_op(1'b0, 3'd0, 4'd7, 16'h0000);
      chk("R8 register updated", r_val, 32'h16C);
   endtask

   task automatic t_illegal;
      run_op(1'b1, 3'd1, 4'd2, 16'h0055);
      chk("R10 illegal flag", {31'd0, r_ill}, 32'd1);
      chk("R10 no read", r_nrd, 0);
      chk("R10 no write-back", {31'd0, r_wb}, 32'd0);
      run_op(1'b1, 3'd2, 4'd2, 16'h0088);
      chk("R10 destination absolute legal", {31'd0, r_ill}, 32'd0);
   endtask

   task automatic t_busy_ignore;
      int dones;
      logic [31:0] v;
      dones = 0; v = '0;
      @(negedge clk);
      req_valid = 1'b1; req_is_dst = 1'b0; req_mode = 3'd2; req_reg_idx = 4'd0; req_const = 16'h0088;
      @(negedge clk);
      // second request, register mode, offered while busy
      req_mode = 3'd0; req_reg_idx = 4'd5; req_const = 16'h0000;
      for (int k = 1; k <= 8; k++) begin
         if (k > 1) @(negedge clk);
         if (k == 3) req_valid = 1'b0;
         if (done) begin dones++; v = opnd_value; end
      end
      chk("R11 only first request done", dones, 1);
      chk("R11 first request result", v, memv(32'h88));
      chk("R11 idle afterwards", {31'd0, busy}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++)  rf[i]  = 32'h100 + 32'(i * 16);
      for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
      mem[16] = 32'h0000_0200;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_reg;
      t_imm;
      t_abs;
      t_rind;
      t_mind;
      t_idx;
      t_ainc;
      t_adec;
      t_illegal;
      t_busy_ignore;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule